// File: doc/BRIEF.md
# Shadowed SRAM with Store and Recall Control

This block is a cycle-based model of a 2048 x 8 working RAM in which every word has a nonvolatile shadow copy. The user side is a synchronous RAM port with active-low chip select, write strobe and output enable, an 11-bit address, write data, and a registered read-data output with a valid flag. A store copies the whole working array into the shadow array in one operation. A recall clears the working array and then reloads it from the shadow array. A recall never changes the shadow array.

Three kinds of event start a transfer. A change of the power-good level starts one: a recall when power comes up and a store when power goes away. An active-low hardware store request also starts a store. The third kind is a command made of six read accesses: five fixed prefix addresses and then a final address that selects store or recall. While a transfer runs, the busy output is low, the user port is locked out and the read output is idle. A test port reads the shadow array directly.

Top module: `shadow_sram_ctrl`

## Requirements
- R1: After reset the shadow array is all zeros, `hs_busy_no` is 1, and `rvalid_o` and `rdata_o` are 0.
- R2: While the block is idle and power is steady good, an access with `ce_ni`=0, `we_ni`=1 and `oe_ni`=0 gives `rvalid_o`=1 and the addressed word on `rdata_o` one cycle later. In every other cycle `rvalid_o`=0 and `rdata_o`=0.
- R3: While the block is idle and power is steady good, an access with `ce_ni`=0 and `we_ni`=0 writes `wdata_i` at `addr_i`. The level of `oe_ni` has no effect on the write.
- R4: If `pwr_good_i` goes from 1 to 0 while the block is idle, a store starts. If `pwr_good_i` goes from 0 to 1 while the block is idle, a recall starts. `hs_busy_no` is 0 for exactly STORE_CYC cycles for a store (default 64) and RECALL_CYC cycles for a recall (default 8), starting the cycle after the triggering edge.
- R5: A store copies every working word into the shadow array at the same address. `tap_data_o` shows the shadow word at `tap_addr_i` combinationally.
- R6: A recall replaces every working word with its shadow word, including words written since the last store. The shadow array does not change.
- R7: `hs_req_ni`=0 sampled while the block is idle and power is steady good starts a store.
- R8: Six accepted reads start a transfer: addresses 0x2A5, 0x55A, 0x0F0, 0x70F and 0x3C3, in that order, then 0x4CC for a store or 0x133 for a recall. Cycles with `ce_ni`=1 in between do not break the command.
- R9: An accepted write inside the command cancels it. So does an accepted read that does not match the next expected address. If that read is of 0x2A5, the command restarts at its second step.
- R10: While `hs_busy_no`=0, reads and writes have no effect, and `rvalid_o` and `rdata_o` stay 0.
- R11: While power is not steady good (`pwr_good_i` low now or in the previous cycle), accesses are ignored: there is no write, no read data and no command progress.
- R12: When triggers coincide, a power-loss store wins, then a power-up recall, then the hardware store, then the software command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip select, active low |
| we_ni | input | 1 | Write strobe, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | 11 | Word address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0 when idle |
| rvalid_o | output | 1 | Read data valid |
| pwr_good_i | input | 1 | Power-good level |
| hs_req_ni | input | 1 | Hardware store request, active low |
| hs_busy_no | output | 1 | Transfer in progress, active low |
| tap_addr_i | input | 11 | Test port shadow address |
| tap_data_o | output | 8 | Test port shadow word |

## Verification
The assertions assume that every input is a synchronous level, sampled once per rising edge. They treat `pwr_good_i` as a clean digital signal with no glitches, and they assume that STORE_CYC and RECALL_CYC are both at least 2. The stimulus meets these assumptions. It changes inputs only on falling clock edges. It toggles power and pulses the hardware request only with all other inputs steady. It always lets a transfer run to completion.

// File: rtl/shadow_sram_pkg.sv
package shadow_sram_pkg;
  typedef enum logic [1:0] {
    XF_IDLE,
    XF_STORE,
    XF_RCL_CLR,
    XF_RCL_LOAD
  } xf_state_e;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/shadow_sram_seq_det.sv
module shadow_sram_seq_det #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned PRE_N  = 5,
  parameter logic [PRE_N*ADDR_W-1:0] PREFIX = '0,
  parameter logic [ADDR_W-1:0] STORE_ADDR = '0,
  parameter logic [ADDR_W-1:0] RCL_ADDR   = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              acc_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              fire_store_o,
  output logic              fire_rcl_o
);
  localparam int unsigned IDX_W = $clog2(PRE_N + 1);

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [ADDR_W-1:0] pre_tbl [PRE_N];
  logic              hit_pre, at_last;

  for (genvar g = 0; g < PRE_N; g++) begin : g_pre
    assign pre_tbl[g] = PREFIX[g*ADDR_W +: ADDR_W];
  end

  always_comb begin
    hit_pre = 1'b0;
    for (int i = 0; i < PRE_N; i++) begin
      if (idx_q == IDX_W'(i) && addr_i == pre_tbl[i]) hit_pre = 1'b1;
    end
  end

  assign at_last = (idx_q == IDX_W'(PRE_N));

  always_comb begin
    idx_d        = idx_q;
    fire_store_o = 1'b0;
    fire_rcl_o   = 1'b0;
    if (clr_i) begin
      idx_d = '0;
    end else if (acc_i) begin
      if (!rd_i) begin
        idx_d = '0;
      end else if (hit_pre) begin
        idx_d = idx_q + 1'b1;
      end else if (at_last && addr_i == STORE_ADDR) begin
        fire_store_o = 1'b1;
        idx_d        = '0;
      end else if (at_last && addr_i == RCL_ADDR) begin
        fire_rcl_o = 1'b1;
        idx_d      = '0;
      end else if (addr_i == pre_tbl[0]) begin
        idx_d = IDX_W'(1);
      end else begin
        idx_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else         idx_q <= idx_d;
  end
endmodule

// File: rtl/shadow_sram_xfer_fsm.sv
module shadow_sram_xfer_fsm
  import shadow_sram_pkg::*;
#(
  parameter int unsigned STORE_CYC  = 64,
  parameter int unsigned RECALL_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic hs_req_ni,
  input  logic sw_store_i,
  input  logic sw_rcl_i,
  output logic busy_o,
  output logic pwr_q_o,
  output logic pwr_ok_o,
  output logic clear_o,
  output logic commit_store_o,
  output logic commit_rcl_o
);
  localparam int unsigned MAX_CYC = max_u(STORE_CYC, RECALL_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  xf_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pwr_q;
  logic             idle, start_store, start_rcl;

  assign idle     = (state_q == XF_IDLE);
  assign pwr_ok_o = pwr_q && pwr_good_i;
  assign pwr_q_o  = pwr_q;

  // priority: power loss, power up, hardware pin, software command
  assign start_store = idle && ((pwr_q && !pwr_good_i) ||
                                (pwr_ok_o && !hs_req_ni) || sw_store_i);
  assign start_rcl   = idle && !start_store &&
                       ((!pwr_q && pwr_good_i) || sw_rcl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XF_IDLE;
      cnt_q   <= '0;
      pwr_q   <= 1'b0;
    end else begin
      pwr_q <= pwr_good_i;
      unique case (state_q)
        XF_IDLE: begin
          if (start_store) begin
            state_q <= XF_STORE;
            cnt_q   <= CNT_W'(STORE_CYC - 1);
          end else if (start_rcl) begin
            state_q <= XF_RCL_CLR;
            cnt_q   <= CNT_W'(RECALL_CYC - 1);
          end
        end
        XF_STORE: begin
          if (cnt_q == '0) state_q <= XF_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        XF_RCL_CLR: begin
          state_q <= XF_RCL_LOAD;
          cnt_q   <= cnt_q - 1'b1;
        end
        XF_RCL_LOAD: begin
          if (cnt_q == '0) state_q <= XF_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= XF_IDLE;
      endcase
    end
  end

  assign busy_o         = !idle;
  assign clear_o        = (state_q == XF_RCL_CLR);
  assign commit_store_o = (state_q == XF_STORE) && (cnt_q == '0);
  assign commit_rcl_o   = (state_q == XF_RCL_LOAD) && (cnt_q == '0);
endmodule

// File: rtl/shadow_sram_arrays.sv
module shadow_sram_arrays #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              clear_i,
  input  logic              commit_store_i,
  input  logic              commit_rcl_i,
  input  logic [ADDR_W-1:0] tap_addr_i,
  output logic [DATA_W-1:0] tap_data_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] work_q   [DEPTH];
  logic [DATA_W-1:0] shadow_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) work_q[i] <= '0;
    end else if (clear_i) begin
      for (int i = 0; i < DEPTH; i++) work_q[i] <= '0;
    end else if (commit_rcl_i) begin
      for (int i = 0; i < DEPTH; i++) work_q[i] <= shadow_q[i];
    end else if (we_i) begin
      work_q[addr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) shadow_q[i] <= '0;
    end else if (commit_store_i) begin
      for (int i = 0; i < DEPTH; i++) shadow_q[i] <= work_q[i];
    end
  end

  assign rdata_o    = work_q[addr_i];
  assign tap_data_o = shadow_q[tap_addr_i];
endmodule

// File: rtl/shadow_sram_ctrl.sv
module shadow_sram_ctrl #(
  parameter int unsigned ADDR_W     = 11,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned STORE_CYC  = 64,
  parameter int unsigned RECALL_CYC = 8,
  parameter int unsigned PRE_N      = 5,
  parameter logic [PRE_N*ADDR_W-1:0] SEQ_PREFIX =
    {11'h3C3, 11'h70F, 11'h0F0, 11'h55A, 11'h2A5},
  parameter logic [ADDR_W-1:0] SEQ_STORE_ADDR = 11'h4CC,
  parameter logic [ADDR_W-1:0] SEQ_RCL_ADDR   = 11'h133
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  input  logic              pwr_good_i,
  input  logic              hs_req_ni,
  output logic              hs_busy_no,
  input  logic [ADDR_W-1:0] tap_addr_i,
  output logic [DATA_W-1:0] tap_data_o
);
  logic busy, pwr_q, pwr_ok, clear, commit_st, commit_rc, sw_st, sw_rc;
  logic accept, acc, wr_acc, rd_out;
  logic [DATA_W-1:0] arr_rdata, rdata_q;
  logic              rvalid_q;

  assign accept = !busy && pwr_ok;
  assign acc    = accept && !ce_ni;
  assign wr_acc = acc && !we_ni;
  assign rd_out = acc && we_ni && !oe_ni;

  shadow_sram_xfer_fsm #(
    .STORE_CYC (STORE_CYC),
    .RECALL_CYC(RECALL_CYC)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pwr_good_i    (pwr_good_i),
    .hs_req_ni     (hs_req_ni),
    .sw_store_i    (sw_st),
    .sw_rcl_i      (sw_rc),
    .busy_o        (busy),
    .pwr_q_o       (pwr_q),
    .pwr_ok_o      (pwr_ok),
    .clear_o       (clear),
    .commit_store_o(commit_st),
    .commit_rcl_o  (commit_rc)
  );

  shadow_sram_seq_det #(
    .ADDR_W    (ADDR_W),
    .PRE_N     (PRE_N),
    .PREFIX    (SEQ_PREFIX),
    .STORE_ADDR(SEQ_STORE_ADDR),
    .RCL_ADDR  (SEQ_RCL_ADDR)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (!accept),
    .acc_i       (acc),
    .rd_i        (we_ni),
    .addr_i      (addr_i),
    .fire_store_o(sw_st),
    .fire_rcl_o  (sw_rc)
  );

  shadow_sram_arrays #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_arr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .we_i          (wr_acc),
    .addr_i        (addr_i),
    .wdata_i       (wdata_i),
    .rdata_o       (arr_rdata),
    .clear_i       (clear),
    .commit_store_i(commit_st),
    .commit_rcl_i  (commit_rc),
    .tap_addr_i    (tap_addr_i),
    .tap_data_o    (tap_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_out;
      rdata_q  <= rd_out ? arr_rdata : '0;
    end
  end

  // a read that lands on the edge that starts a transfer is suppressed
  assign rvalid_o   = rvalid_q && !busy;
  assign rdata_o    = busy ? '0 : rdata_q;
  assign hs_busy_no = !busy;
endmodule

// File: rtl/shadow_sram_ctrl_chk.sv
module shadow_sram_ctrl_chk #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned STORE_CYC  = 64,
  parameter int unsigned RECALL_CYC = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              we_ni,
  input logic              oe_ni,
  input logic              pwr_good_i,
  input logic              hs_req_ni,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rvalid_o,
  input logic              hs_busy_no,
  input logic              pwr_q
);
  int unsigned busy_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         busy_len <= 0;
    else if (hs_busy_no) busy_len <= 0;
    else                 busy_len <= busy_len + 1;
  end

  assert_idle_while_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hs_busy_no |-> (!rvalid_o && rdata_o == '0));

  assert_no_stray_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(!ce_ni && we_ni && !oe_ni && pwr_good_i));

  assert_quiet_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> rdata_o == '0);

  assert_pwr_loss_store_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_busy_no && pwr_q && !pwr_good_i) |=> !hs_busy_no);

  assert_pwr_up_recall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_busy_no && !pwr_q && pwr_good_i) |=> !hs_busy_no);

  assert_busy_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_busy_no) |-> (busy_len == STORE_CYC || busy_len == RECALL_CYC));

  assert_hw_store_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_busy_no && pwr_q && pwr_good_i && !hs_req_ni) |=> !hs_busy_no);

  assert_unpowered_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_q |=> !rvalid_o);
endmodule

bind shadow_sram_ctrl shadow_sram_ctrl_chk #(
  .DATA_W    (DATA_W),
  .STORE_CYC (STORE_CYC),
  .RECALL_CYC(RECALL_CYC)
) u_chk (.*);

// File: tb/shadow_sram_ctrl_tb.sv
`timescale 1ns/1ps
module shadow_sram_ctrl_tb;
  localparam int ST_CYC = 64;
  localparam int RC_CYC = 8;
  localparam int DEPTH  = 2048;
  localparam logic [10:0] PRE [5] = '{11'h2A5, 11'h55A, 11'h0F0, 11'h70F, 11'h3C3};
  localparam logic [10:0] ST_A = 11'h4CC;
  localparam logic [10:0] RC_A = 11'h133;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [10:0] addr = '0, tap_addr = '0;
  logic [7:0]  wdata = '0;
  logic pwr_good = 1'b0, hs_req_n = 1'b1;
  logic [7:0] rdata, tap_data;
  logic rvalid, busy_n;

  always #10 clk = ~clk;

  shadow_sram_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .pwr_good_i(pwr_good), .hs_req_ni(hs_req_n), .hs_busy_no(busy_n),
    .tap_addr_i(tap_addr), .tap_data_o(tap_data)
  );

  int n_checks = 0, n_err = 0;
  bit done = 1'b0;
  string cur_tag = "R1";

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  endtask

  // reference model
  logic [7:0] m_work [DEPTH];
  logic [7:0] m_shadow [DEPTH];
  int m_mode, m_left, m_idx, m_start, m_sw;
  bit m_pwr_q, m_rv, m_acc, m_ok;
  logic [7:0] m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin m_work[i] = 0; m_shadow[i] = 0; end
      m_mode = 0; m_left = 0; m_idx = 0; m_pwr_q = 0; m_rv = 0; m_rd = 0;
    end else begin
      m_rv = 0; m_rd = 0; m_sw = 0; m_start = 0;
      if (m_mode != 0) begin
        m_idx = 0;
        if (m_mode == 2 && m_left == RC_CYC)
          for (int i = 0; i < DEPTH; i++) m_work[i] = 0;
        m_left--;
        if (m_left == 0) begin
          if (m_mode == 1) for (int i = 0; i < DEPTH; i++) m_shadow[i] = m_work[i];
          else             for (int i = 0; i < DEPTH; i++) m_work[i] = m_shadow[i];
          m_mode = 0;
        end
      end else begin
        m_ok  = pwr_good && m_pwr_q;
        m_acc = m_ok && !ce_n;
        if (m_acc && we_n && !oe_n) begin m_rv = 1; m_rd = m_work[addr]; end
        if (m_acc && !we_n) m_work[addr] = wdata;
        if (!m_ok) m_idx = 0;
        else if (m_acc) begin
          if (!we_n) m_idx = 0;
          else if (m_idx < 5 && addr == PRE[m_idx]) m_idx++;
          else if (m_idx == 5 && addr == ST_A) begin m_sw = 1; m_idx = 0; end
          else if (m_idx == 5 && addr == RC_A) begin m_sw = 2; m_idx = 0; end
          else m_idx = (addr == PRE[0]) ? 1 : 0;
        end
        if (m_pwr_q && !pwr_good)       m_start = 1;
        else if (!m_pwr_q && pwr_good)  m_start = 2;
        else if (m_ok && !hs_req_n)     m_start = 1;
        else                            m_start = m_sw;
        if (m_start == 1) begin m_mode = 1; m_left = ST_CYC; end
        if (m_start == 2) begin m_mode = 2; m_left = RC_CYC; end
      end
      m_pwr_q = pwr_good;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic bit e_rv = m_rv && (m_mode == 0);
      automatic logic [7:0] e_rd = e_rv ? m_rd : 8'h00;
      check(busy_n === (m_mode == 0), cur_tag, "busy_n", int'(busy_n), int'(m_mode == 0));
      check(rvalid === e_rv, cur_tag, "rvalid", int'(rvalid), int'(e_rv));
      check(rdata === e_rd, cur_tag, "rdata", int'(rdata), int'(e_rd));
    end
  end

  task automatic drive(bit c, bit w, bit o, logic [10:0] a, logic [7:0] d);
    @(negedge clk);
    ce_n = c; we_n = w; oe_n = o; addr = a; wdata = d;
  endtask
  task automatic idle(int n);
    repeat (n) drive(1, 1, 1, '0, '0);
  endtask
  task automatic wr(logic [10:0] a, logic [7:0] d);
    drive(0, 0, 1, a, d);
  endtask
  task automatic rd(logic [10:0] a);
    drive(0, 1, 0, a, '0);
  endtask
  task automatic wait_idle();
    idle(1);
    while (m_mode != 0) idle(1);
    idle(1);
  endtask
  task automatic tap_chk(logic [10:0] a, string tag);
    tap_addr = a;
    #1;
    check(tap_data === m_shadow[a], tag, "tap_data", int'(tap_data), int'(m_shadow[a]));
  endtask
  task automatic sw_cmd(logic [10:0] fin);
    for (int i = 0; i < 5; i++) rd(PRE[i]);
    rd(fin);
  endtask
  function automatic logic [7:0] pat(int a);
    return 8'(a * 37 + (a >> 3) + 1);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_tag = "R1";
    idle(2);
    tap_chk(0, "R1");
    check(tap_data === 8'h00, "R1", "shadow word 0", int'(tap_data), 0);
    tap_chk(2047, "R1");
    check(busy_n === 1'b1, "R1", "busy_n after reset", int'(busy_n), 1);

    // accesses with power down are ignored
    cur_tag = "R11";
    wr(5, 8'hAA); rd(5); idle(2);

    // power up recall
    cur_tag = "R4";
    pwr_good = 1'b1;
    wait_idle();
    cur_tag = "R11";
    rd(5); idle(1);
    check(rvalid === 1'b1 && rdata === 8'h00, "R11", "word 5 after unpowered write",
          int'(rdata), 0);

    // fill the whole array, one write with output enable low
    cur_tag = "R3";
    for (int a = 0; a < DEPTH; a++) wr(11'(a), pat(a));
    drive(0, 0, 0, 11'd7, 8'h77);
    idle(1);
    cur_tag = "R2";
    for (int a = 0; a < DEPTH; a++) rd(11'(a));
    drive(0, 1, 1, 11'd3, '0);
    drive(1, 1, 0, 11'd3, '0);
    idle(2);

    // hardware store with lockout probing
    cur_tag = "R7";
    hs_req_n = 1'b0;
    idle(1);
    hs_req_n = 1'b1;
    cur_tag = "R10";
    wr(9, 8'hEE); rd(9); rd(10);
    wait_idle();
    rd(9); idle(1);
    check(rdata === pat(9), "R10", "word 9 after locked write", int'(rdata), int'(pat(9)));
    for (int a = 0; a < DEPTH; a++) tap_chk(11'(a), "R5");
    check(tap_data === pat(2047), "R5", "shadow 2047", int'(tap_data), int'(pat(2047)));

    // software recall restores words written since the store
    cur_tag = "R3";
    wr(9, 8'h11); wr(100, 8'h22); idle(1);
    cur_tag = "R8";
    sw_cmd(RC_A);
    wait_idle();
    cur_tag = "R6";
    rd(9); rd(100); idle(1);
    tap_chk(9, "R6");
    tap_chk(100, "R6");

    // aborts: write in the middle, wrong final read
    cur_tag = "R9";
    rd(PRE[0]); rd(PRE[1]); wr(50, 8'h33);
    rd(PRE[2]); rd(PRE[3]); rd(PRE[4]); rd(ST_A); idle(3);
    check(busy_n === 1'b1, "R9", "no store after write abort", int'(busy_n), 1);
    for (int i = 0; i < 5; i++) rd(PRE[i]);
    rd(11'h001); rd(ST_A); idle(3);
    check(busy_n === 1'b1, "R9", "no store after wrong read", int'(busy_n), 1);
    // restart on first address, with deselected gaps
    rd(PRE[0]); rd(PRE[1]); rd(PRE[0]); idle(1);
    rd(PRE[1]); idle(2); rd(PRE[2]); rd(PRE[3]); rd(PRE[4]); rd(ST_A);
    wait_idle();
    tap_chk(50, "R9");
    check(tap_data === 8'h33, "R9", "shadow 50 after restarted store", int'(tap_data), 'h33);

    // power loss store, then power up recall
    cur_tag = "R4";
    wr(200, 8'h44); idle(1);
    pwr_good = 1'b0;
    wait_idle();
    tap_chk(200, "R4");
    idle(3);
    pwr_good = 1'b1;
    wait_idle();
    rd(200); rd(50); idle(1);

    // coinciding triggers: hardware store beats software recall
    cur_tag = "R12";
    wr(300, 8'h5C); idle(1);
    for (int i = 0; i < 5; i++) rd(PRE[i]);
    drive(0, 1, 0, RC_A, '0);
    hs_req_n = 1'b0;
    idle(1);
    hs_req_n = 1'b1;
    wait_idle();
    tap_chk(300, "R12");
    check(tap_data === 8'h5C, "R12", "store chosen over recall", int'(tap_data), 'h5C);

    idle(2);
    finish_run();
  end
endmodule